// File: doc/BRIEF.md
# Spread-Spectrum Fractional Divide-Ratio Modulator

This block supplies the divide ratio for a fractional-N output clock divider and sweeps that ratio along a triangle so that the divided clock's energy spreads over a band instead of sitting at one frequency. Registers at its inputs give the nominal ratio (12 integer bits, 24 fractional bits), a spread-enable bit, a spread-mode bit (symmetric about nominal, or only toward lower frequency), a magnitude code and a step-rate code. Magnitude and rate are set independently of each other. A fractional divider driven by a fast clock turns the instantaneous ratio into a divided clock by a first-order fractional accumulator whose carry stretches a period by one input cycle.

The sweep is held by a small state machine with three named states. `TRI_IDLE` (spreading off, position parked at the midpoint) moves to `TRI_RISE` when spreading is enabled. `TRI_RISE` moves to `TRI_FALL` when the position reaches its top limit, and `TRI_FALL` moves back to `TRI_RISE` when the position reaches zero. Any state returns to `TRI_IDLE` as soon as spreading is disabled. The magnitude, rate and mode are captured only in `TRI_IDLE` and on arrival at either limit, so a ramp that is under way never changes slope.

With default parameters the position runs from 0 to TOP = 32, midpoint 16. The peak deviation is `dev = (nom_ratio * spread_mag) >> 12`, so one magnitude code is 1/4096 of the nominal ratio (code 10 is about 0.25 %, 102 about 2.5 %, 205 about 5 %), which makes the spread the same fraction for any nominal ratio.

Top module: `ssc_ratio_mod`

## Requirements
- R1: While rst_n is low, ratio_out is 0 and div_out is 0.
- R2: While ss_en is 0, ratio_out equals nom_ratio exactly (one cycle later), whatever spread_mag, mod_rate and ss_down hold.
- R3: While spreading is off the position is held at the midpoint; after ss_en rises in center mode (ss_down = 0) the first ratio different from nominal is nom_ratio + step, with step = dev >> 4.
- R4: In center mode the ratio sweeps between nom_ratio − 16·step and nom_ratio + 16·step, with step = dev >> 4.
- R5: In down mode (ss_down = 1) the ratio sweeps between nom_ratio and nom_ratio + 32·stepd with stepd = dev >> 5, and is never below nom_ratio.
- R6: Each position step lasts mod_rate + 1 clock cycles, so one full triangle lasts 64·(mod_rate + 1) cycles.
- R7: Changes to spread_mag, mod_rate or ss_down made during a ramp take effect only when the position arrives at a limit; until then the ratio stays on the old slope.
- R8: With a zero fractional part, every div_out period (rising edge to rising edge) is exactly the integer part of the ratio in cycles; integer parts below 2 are treated as 2.
- R9: With fractional part f, n consecutive div_out periods last n·(integer part) + n·f cycles whenever n·f is whole, for any accumulator starting value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ss_en | input | 1 | 1 enables the triangle sweep |
| ss_down | input | 1 | 0 = symmetric spread, 1 = spread toward lower frequency only |
| nom_ratio | input | 36 | Nominal divide ratio, 12.24 fixed point |
| spread_mag | input | 8 | Peak deviation in units of nominal/4096 |
| mod_rate | input | 8 | Cycles per position step, minus one |
| ratio_out | output | 36 | Instantaneous divide ratio, 12.24 fixed point |
| div_out | output | 1 | Divided clock |

## Verification
A position counter that drifts past a limit or skips a step shows at ratio_out within one step time as a value off the step grid or an extreme beyond nom ± 16·step. A slope captured at the wrong moment shows as a ramp value that is not a multiple of the old step before the next turning point. A wrong state or a missed turning point stretches the measured triangle period, visible within one period, and a faulty fractional accumulator alters the summed divider period after as many periods as it takes for n·f to become whole.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    typedef enum logic [1:0] {
        TRI_IDLE = 2'd0,
        TRI_RISE = 2'd1,
        TRI_FALL = 2'd2
    } tri_state_e;

endpackage

// File: rtl/ssc_tri_fsm.sv
module ssc_tri_fsm
    import ssc_pkg::*;
#(
    parameter int TRI_LOG = 5,
    parameter int RATE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_en,
    input  logic [RATE_W-1:0] rate_in,
    output tri_state_e        state_q,
    output logic [TRI_LOG:0]  pos_q,
    output logic              cfg_load
);

    localparam int PW = TRI_LOG + 1;
    localparam logic [PW-1:0] TOP_V  = PW'(2 ** TRI_LOG);
    localparam logic [PW-1:0] MID_V  = PW'(2 ** (TRI_LOG - 1));
    localparam logic [PW-1:0] ONE_V  = PW'(1);
    localparam logic [PW-1:0] TOPM_V = TOP_V - ONE_V;

    tri_state_e        state_d;
    logic [RATE_W-1:0] cnt_q;
    logic [RATE_W-1:0] rate_q;
    logic              tick;
    logic              at_top;
    logic              at_bot;
    logic              arrive;

    always_comb begin
        tick     = (cnt_q == '0);
        at_top   = (state_q == TRI_RISE) && tick && (pos_q == TOPM_V);
        at_bot   = (state_q == TRI_FALL) && tick && (pos_q == ONE_V);
        arrive   = at_top || at_bot;
        cfg_load = (state_q == TRI_IDLE) || arrive;
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        if (!ss_en) begin
            state_d = TRI_IDLE;
        end else begin
            unique case (state_q)
                TRI_IDLE: state_d = TRI_RISE;
                TRI_RISE: if (at_top) state_d = TRI_FALL;
                TRI_FALL: if (at_bot) state_d = TRI_RISE;
                default:  state_d = TRI_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TRI_IDLE;
        else        state_q <= state_d;
    end

    // position and step prescaler
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= MID_V;
            cnt_q  <= '0;
            rate_q <= '0;
        end else if (!ss_en || state_q == TRI_IDLE) begin
            pos_q  <= MID_V;
            cnt_q  <= rate_in;
            rate_q <= rate_in;
        end else if (tick) begin
            pos_q <= (state_q == TRI_RISE) ? pos_q + ONE_V : pos_q - ONE_V;
            if (arrive) begin
                cnt_q  <= rate_in;
                rate_q <= rate_in;
            end else begin
                cnt_q <= rate_q;
            end
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/ssc_ratio_calc.sv
module ssc_ratio_calc #(
    parameter int INT_W     = 12,
    parameter int FRAC_W    = 24,
    parameter int MAG_W     = 8,
    parameter int MAG_SHIFT = 12,
    parameter int TRI_LOG   = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [INT_W+FRAC_W-1:0]   nom,
    input  logic [MAG_W-1:0]          mag_in,
    input  logic                      down_in,
    input  logic                      cfg_load,
    input  logic                      active,
    input  logic [TRI_LOG:0]          pos,
    output logic [INT_W+FRAC_W-1:0]   ratio_q,
    output logic [INT_W+FRAC_W-1:0]   step_q
);

    localparam int RW    = INT_W + FRAC_W;
    localparam int PW    = TRI_LOG + 1;
    localparam int PRODW = RW + MAG_W;
    localparam int OFFW  = RW + PW + 2;
    localparam logic [PW:0] MID_X = (PW + 1)'(2 ** (TRI_LOG - 1));

    logic [PRODW-1:0]       dev_full;
    logic [RW-1:0]          dev;
    logic [RW-1:0]          step_d;
    logic                   down_q;
    logic signed [PW:0]     pos_rel;
    logic signed [OFFW-1:0] step_x;
    logic signed [OFFW-1:0] pos_x;
    logic signed [OFFW-1:0] off;
    logic [RW-1:0]          ratio_d;

    always_comb begin
        dev_full = PRODW'(nom) * PRODW'(mag_in);
        dev      = RW'(dev_full >> MAG_SHIFT);
        step_d   = down_in ? (dev >> TRI_LOG) : (dev >> (TRI_LOG - 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
            down_q <= 1'b0;
        end else if (cfg_load) begin
            step_q <= step_d;
            down_q <= down_in;
        end
    end

    always_comb begin
        pos_rel = down_q ? $signed({1'b0, pos}) : $signed({1'b0, pos} - MID_X);
        step_x  = $signed({{(OFFW - RW){1'b0}}, step_q});
        pos_x   = $signed({{(OFFW - PW - 1){pos_rel[PW]}}, pos_rel});
        off     = step_x * pos_x;
        ratio_d = active ? (nom + off[RW-1:0]) : nom;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ratio_q <= '0;
        else        ratio_q <= ratio_d;
    end

endmodule

// File: rtl/ssc_frac_div.sv
module ssc_frac_div #(
    parameter int INT_W  = 12,
    parameter int FRAC_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [INT_W+FRAC_W-1:0] ratio,
    output logic                    div_out
);

    localparam int LW = INT_W + 1;
    localparam logic [LW-1:0] MIN_LEN = LW'(2);

    logic [FRAC_W-1:0] facc_q;
    logic [FRAC_W-1:0] fsum;
    logic              carry;
    logic [LW-1:0]     len_raw;
    logic [LW-1:0]     len_d;
    logic [LW-1:0]     len_q;
    logic [LW-1:0]     cnt_q;
    logic              wrap;

    always_comb begin
        {carry, fsum} = {1'b0, facc_q} + {1'b0, ratio[FRAC_W-1:0]};
        len_raw       = {1'b0, ratio[INT_W+FRAC_W-1:FRAC_W]} + LW'(carry);
        len_d         = (len_raw < MIN_LEN) ? MIN_LEN : len_raw;
        wrap          = (cnt_q == '0);
        div_out       = (len_q != '0) && (cnt_q >= ((len_q + 1'b1) >> 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            facc_q <= '0;
            len_q  <= '0;
            cnt_q  <= '0;
        end else if (wrap) begin
            facc_q <= fsum;
            len_q  <= len_d;
            cnt_q  <= len_d - 1'b1;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/ssc_ratio_mod.sv
module ssc_ratio_mod
    import ssc_pkg::*;
#(
    parameter int INT_W     = 12,
    parameter int FRAC_W    = 24,
    parameter int MAG_W     = 8,
    parameter int MAG_SHIFT = 12,
    parameter int RATE_W    = 8,
    parameter int TRI_LOG   = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ss_en,
    input  logic                    ss_down,
    input  logic [INT_W+FRAC_W-1:0] nom_ratio,
    input  logic [MAG_W-1:0]        spread_mag,
    input  logic [RATE_W-1:0]       mod_rate,
    output logic [INT_W+FRAC_W-1:0] ratio_out,
    output logic                    div_out
);

    localparam int RW = INT_W + FRAC_W;

    tri_state_e       st_w;
    logic [TRI_LOG:0] pos_w;
    logic             load_w;
    logic             active_w;
    logic [RW-1:0]    step_w;

    assign active_w = (st_w != TRI_IDLE);

    ssc_tri_fsm #(
        .TRI_LOG (TRI_LOG),
        .RATE_W  (RATE_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ss_en    (ss_en),
        .rate_in  (mod_rate),
        .state_q  (st_w),
        .pos_q    (pos_w),
        .cfg_load (load_w)
    );

    ssc_ratio_calc #(
        .INT_W     (INT_W),
        .FRAC_W    (FRAC_W),
        .MAG_W     (MAG_W),
        .MAG_SHIFT (MAG_SHIFT),
        .TRI_LOG   (TRI_LOG)
    ) u_calc (
        .clk      (clk),
        .rst_n    (rst_n),
        .nom      (nom_ratio),
        .mag_in   (spread_mag),
        .down_in  (ss_down),
        .cfg_load (load_w),
        .active   (active_w),
        .pos      (pos_w),
        .ratio_q  (ratio_out),
        .step_q   (step_w)
    );

    ssc_frac_div #(
        .INT_W  (INT_W),
        .FRAC_W (FRAC_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .ratio   (ratio_out),
        .div_out (div_out)
    );

endmodule

// File: rtl/ssc_ratio_mod_chk.sv
module ssc_ratio_mod_chk
    import ssc_pkg::*;
#(
    parameter int INT_W   = 12,
    parameter int FRAC_W  = 24,
    parameter int TRI_LOG = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    ss_en,
    input logic [INT_W+FRAC_W-1:0] nom_ratio,
    input logic [INT_W+FRAC_W-1:0] ratio_out,
    input tri_state_e              tri_state,
    input logic [TRI_LOG:0]        tri_pos,
    input logic [INT_W+FRAC_W-1:0] step_q
);

    localparam int PW = TRI_LOG + 1;
    localparam logic [PW-1:0] TOP_V = PW'(2 ** TRI_LOG);
    localparam logic [PW-1:0] MID_V = PW'(2 ** (TRI_LOG - 1));
    localparam logic [PW-1:0] ONE_V = PW'(1);

    logic [1:0] warm_cnt;
    logic       warm;

    always_ff @(posedge clk) begin
        if (!rst_n)                warm_cnt <= '0;
        else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
    end
    assign warm = (warm_cnt == 2'd3);

    // R2: spreading off two samples ago means the nominal ratio is passed through
    a_r2_disabled_nominal: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !$past(ss_en, 2)) |-> (ratio_out == $past(nom_ratio)));

    // R3: idle state keeps the position parked at the midpoint
    a_r3_idle_midpoint: assert property (@(posedge clk) disable iff (!rst_n)
        (tri_state == TRI_IDLE) |-> (tri_pos == MID_V));

    // R4: position never leaves the range 0..TOP
    a_r4_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
        tri_pos <= TOP_V);

    // R6: while sweeping, the position moves by at most one per cycle
    a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && tri_state != TRI_IDLE && $past(tri_state) != TRI_IDLE)
        |-> (tri_pos == $past(tri_pos) || tri_pos == $past(tri_pos) + ONE_V
             || tri_pos == $past(tri_pos) - ONE_V));

    // R7: slope may only change at a turning point
    a_r7_step_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && tri_state != TRI_IDLE && $past(tri_state) != TRI_IDLE
         && tri_pos != '0 && tri_pos != TOP_V) |-> $stable(step_q));

endmodule

bind ssc_ratio_mod ssc_ratio_mod_chk #(
    .INT_W   (INT_W),
    .FRAC_W  (FRAC_W),
    .TRI_LOG (TRI_LOG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ss_en     (ss_en),
    .nom_ratio (nom_ratio),
    .ratio_out (ratio_out),
    .tri_state (st_w),
    .tri_pos   (pos_w),
    .step_q    (step_w)
);

// File: tb/sim_ssc_ratio_mod.sv
`timescale 1ns/1ps
module sim_ssc_ratio_mod;

    localparam longint NOM100 = 64'd100 << 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ss_en = 1'b0;
    logic        ss_down = 1'b0;
    logic [35:0] nom_ratio = '0;
    logic [7:0]  spread_mag = '0;
    logic [7:0]  mod_rate = '0;
    logic [35:0] ratio_out;
    logic        div_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ssc_ratio_mod u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ss_en      (ss_en),
        .ss_down    (ss_down),
        .nom_ratio  (nom_ratio),
        .spread_mag (spread_mag),
        .mod_rate   (mod_rate),
        .ratio_out  (ratio_out),
        .div_out    (div_out)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint dev_of(input longint nom, input int mag);
        return (nom * mag) >> 12;
    endfunction

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic observe(input int n, output longint mn, output longint mx);
        mn = longint'(ratio_out);
        mx = mn;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (longint'(ratio_out) < mn) mn = longint'(ratio_out);
            if (longint'(ratio_out) > mx) mx = longint'(ratio_out);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        nom_ratio = 36'(NOM100);
        cycles(4);
        chk(ratio_out == '0, "R1 ratio in reset", longint'(ratio_out), 0);
        chk(div_out == 1'b0, "R1 div in reset", longint'(div_out), 0);
        rst_n = 1'b1;
        cycles(3);
        chk(longint'(ratio_out) == NOM100, "R2 nominal after reset", longint'(ratio_out), NOM100);
    endtask

    task automatic t_disabled;
        bit ok = 1'b1;
        longint bad = 0;
        ss_en = 1'b0;
        nom_ratio = 36'(NOM100);
        cycles(3);
        for (int i = 0; i < 40; i++) begin
            spread_mag = 8'(i * 7);
            mod_rate = 8'(i);
            ss_down = i[0];
            @(negedge clk);
            if (longint'(ratio_out) != NOM100) begin ok = 1'b0; bad = longint'(ratio_out); end
        end
        chk(ok, "R2 disabled ignores settings", bad, NOM100);
    endtask

    task automatic t_center(input int mag, input int rate);
        longint step = dev_of(NOM100, mag) >> 4;
        longint mn, mx;
        ss_en = 1'b0; ss_down = 1'b0; spread_mag = 8'(mag); mod_rate = 8'(rate);
        nom_ratio = 36'(NOM100);
        cycles(3);
        ss_en = 1'b1;
        for (int i = 0; i < 2000 && longint'(ratio_out) == NOM100; i++) @(negedge clk);
        chk(longint'(ratio_out) == NOM100 + step, "R3 first move from midpoint",
            longint'(ratio_out), NOM100 + step);
        observe(2 * 64 * (rate + 1) + 8, mn, mx);
        chk(mx == NOM100 + 16 * step, "R4 center max", mx, NOM100 + 16 * step);
        chk(mn == NOM100 - 16 * step, "R4 center min", mn, NOM100 - 16 * step);
        ss_en = 1'b0;
        cycles(3);
    endtask

    task automatic t_down(input int mag, input int rate);
        longint stepd = dev_of(NOM100, mag) >> 5;
        longint mn, mx;
        ss_en = 1'b0; ss_down = 1'b1; spread_mag = 8'(mag); mod_rate = 8'(rate);
        cycles(3);
        ss_en = 1'b1;
        cycles(2);
        observe(2 * 64 * (rate + 1) + 8, mn, mx);
        chk(mx == NOM100 + 32 * stepd, "R5 down max", mx, NOM100 + 32 * stepd);
        chk(mn == NOM100, "R5 down floor at nominal", mn, NOM100);
        ss_en = 1'b0; ss_down = 1'b0;
        cycles(3);
    endtask

    task automatic t_period(input int rate);
        longint step = dev_of(NOM100, 41) >> 4;
        longint top = NOM100 + 16 * step;
        int t0 = 0, t1 = 0, n = 0;
        ss_en = 1'b0; ss_down = 1'b0; spread_mag = 8'd41; mod_rate = 8'(rate);
        cycles(3);
        ss_en = 1'b1;
        for (int i = 0; i < 5000 && longint'(ratio_out) != top; i++) begin @(negedge clk); n++; end
        t0 = n;
        for (int i = 0; i < 5000 && longint'(ratio_out) == top; i++) begin @(negedge clk); n++; end
        for (int i = 0; i < 5000 && longint'(ratio_out) != top; i++) begin @(negedge clk); n++; end
        t1 = n;
        chk(t1 - t0 == 64 * (rate + 1), "R6 triangle period", t1 - t0, 64 * (rate + 1));
        ss_en = 1'b0;
        cycles(3);
    endtask

    task automatic t_midramp;
        longint sa = dev_of(NOM100, 41) >> 4;
        longint sb = dev_of(NOM100, 100) >> 4;
        longint base = NOM100 - 16 * sa;
        longint mn, mx, bad = 0;
        bit ok = 1'b1, hit = 1'b0;
        ss_en = 1'b0; ss_down = 1'b0; spread_mag = 8'd41; mod_rate = 8'd2;
        cycles(3);
        ss_en = 1'b1;
        cycles(30);
        spread_mag = 8'd100;
        for (int i = 0; i < 400 && !hit; i++) begin
            @(negedge clk);
            if (longint'(ratio_out) == NOM100 + 16 * sb) hit = 1'b1;
            else if ((longint'(ratio_out) - base) % sa != 0 ||
                     longint'(ratio_out) > NOM100 + 15 * sa) begin
                ok = 1'b0; bad = longint'(ratio_out);
            end
        end
        chk(ok, "R7 old slope kept until turning point", bad, NOM100 + 15 * sa);
        chk(hit, "R7 new peak at turning point", longint'(ratio_out), NOM100 + 16 * sb);
        observe(200, mn, mx);
        chk(mn == NOM100 - 16 * sb, "R7 new slope after turn", mn, NOM100 - 16 * sb);
        ss_en = 1'b0;
        cycles(3);
    endtask

    task automatic t_div(input longint ip, input longint fr, input int nper,
                         input longint exp_total, input string req);
        int n = 0, first = 0, prev_edge = 0, edges = 0;
        bit pv = 1'b0, per_ok = 1'b1;
        int bad_per = 0;
        ss_en = 1'b0;
        nom_ratio = 36'((ip << 24) + fr);
        cycles(300);
        pv = div_out;
        while (edges <= nper && n < 5000) begin
            @(negedge clk);
            n++;
            if (!pv && div_out) begin
                if (edges == 0) first = n;
                else if (fr == 0 && (n - prev_edge) != int'(ip)) begin
                    per_ok = 1'b0; bad_per = n - prev_edge;
                end
                prev_edge = n;
                edges++;
            end
            pv = div_out;
        end
        chk(longint'(prev_edge - first) == exp_total, req, prev_edge - first, exp_total);
        if (fr == 0) chk(per_ok, "R8 each period equals integer part", bad_per, ip);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog all actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_disabled();
        t_center(41, 2);
        t_center(100, 0);
        t_down(41, 1);
        t_down(205, 0);
        t_period(2);
        t_period(5);
        t_midramp();
        t_div(5, 0, 4, 20, "R8 integer ratio 5");
        t_div(5, 64'd1 << 23, 10, 55, "R9 ratio 5.5");
        t_div(7, 64'd1 << 22, 4, 29, "R9 ratio 7.25");
        t_div(3, 64'd3 << 22, 4, 15, "R9 ratio 3.75");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule